// File: doc/BRIEF.md
# Heartbeat-Scheduled Direct Clock-Crossing Link

This block carries a small data word from a sending clock domain to a receiving clock domain without a FIFO and without a request/acknowledge handshake. The two clocks run at a fixed rational frequency ratio. A heartbeat is the shortest interval that holds a whole number of cycles of both clocks. Each side keeps a rotating slot pattern with one bit per cycle of the heartbeat. A set bit marks a cycle in which that side may act.

On the sending side, a send slot loads the holding register with the word on `tx_data` and with the `tx_valid` flag beside it. The register then keeps its value until the next send slot. On the receiving side, a receive slot samples that register. A valid word is presented on `rx_data` together with a one-cycle `rx_valid` pulse. The integrator picks the two patterns from the clock ratio and the timing margins. Both phase counters must start at a common heartbeat boundary. With a correct schedule, each send slot is followed by exactly one receive slot before the next send slot.

Top module: `hb_cross_link`

## Requirements
- R1: While a domain's reset is asserted, `rx_valid` and `rx_data` are 0, and `tx_slot` shows the pattern bit of cycle 0.
- R2: `tx_slot` equals bit c of `TX_PATTERN`, where c is the index of the sender cycle about to begin. The first sender edge after reset release is cycle 0, and the index wraps to 0 after `TX_LEN` cycles. The receiving side rotates through `RX_PATTERN` in the same way over `RX_LEN` cycles.
- R3: At a sender edge in a send slot, the holding register loads `tx_valid` and `tx_data`. At a sender edge outside a send slot, both inputs are ignored and the register keeps its value.
- R4: At a receiver edge whose slot bit is 1 and whose sampled valid flag is 1, `rx_valid` is 1 for the next receiver cycle and `rx_data` takes the sampled word. In every other cycle `rx_valid` is 0.
- R5: While `rx_valid` is 0, `rx_data` keeps the last received word.
- R6: The default patterns are sender 8'b0110_1011 (slots in cycles 0, 1, 3, 5 and 6) and receiver 5'b11111, with the clocks at 8:5 and aligned to a common heartbeat start. Under these conditions every word loaded with `tx_valid` = 1 appears at `rx_data` exactly once and in order. At most five words move per heartbeat.
- R7: A send slot taken with `tx_valid` = 0 produces no `rx_valid` pulse.
- R8: A held word that no receive slot samples before the next send slot is overwritten and never delivered. With receiver pattern 5'b00001, only words loaded in sender cycle 0 arrive.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_s | input | 1 | Sending-domain clock |
| rst_s_n | input | 1 | Sending-domain reset, active low |
| tx_valid | input | 1 | Word on tx_data is meant to be sent |
| tx_data | input | DATA_W | Word to send |
| tx_slot | output | 1 | The coming sender edge is a send slot |
| clk_r | input | 1 | Receiving-domain clock |
| rst_r_n | input | 1 | Receiving-domain reset, active low |
| rx_valid | output | 1 | One-cycle strobe: a new word is on rx_data |
| rx_data | output | DATA_W | Last received word |

## Verification
The link is driven with several stimulus phases:
- A dense phase with `tx_valid` held high. This shows whether all five slots per heartbeat deliver, with no duplicates and no drops.
- A phase where valid words appear only outside the send slots and the slots see `tx_valid` low. This separates slot gating from valid gating: nothing may arrive.
- A long random phase. This checks ordering under irregular traffic.

A second instance with a single receive slot per heartbeat runs on the same stimulus. It shows that overwrite loss happens exactly as the schedule predicts and only at the permitted receiver phase.

// File: rtl/hb_link_pkg.sv
package hb_link_pkg;

    // width of a phase counter for a ring of len cycles (at least one bit)
    function automatic int unsigned ring_w(input int unsigned len);
        return (len < 2) ? 1 : $clog2(len);
    endfunction

    // true when len is a power of two, so the counter may wrap naturally
    function automatic bit is_pow2(input int unsigned len);
        return (len != 0) && ((len & (len - 1)) == 0);
    endfunction

endpackage

// File: rtl/hb_slot_ring.sv
module hb_slot_ring
    import hb_link_pkg::*;
#(
    parameter int unsigned      LEN     = 8,
    parameter logic [LEN-1:0]   PATTERN = '1
) (
    input  logic clk,
    input  logic rst_n,
    output logic slot_en
);
    localparam int unsigned PW = ring_w(LEN);

    typedef struct packed {
        logic [PW-1:0] phase;
    } ring_t;

    ring_t ring_d, ring_q;

    generate
        if (is_pow2(LEN)) begin : g_natural_wrap
            always_comb begin
                ring_d       = ring_q;
                ring_d.phase = ring_q.phase + 1'b1;
            end
        end else begin : g_compare_wrap
            always_comb begin
                ring_d = ring_q;
                if (ring_q.phase == PW'(LEN - 1)) ring_d.phase = '0;
                else                              ring_d.phase = ring_q.phase + 1'b1;
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ring_q <= '0;
        else        ring_q <= ring_d;
    end

    assign slot_en = PATTERN[ring_q.phase];

    // R2
    phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(ring_q.phase) < int'(LEN));

    // R2
    phase_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(ring_q.phase) == int'(LEN) - 1) |=> (ring_q.phase == '0));

endmodule

// File: rtl/hb_tx_hold.sv
module hb_tx_hold #(
    parameter int unsigned DATA_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_en,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              held_vld,
    output logic [DATA_W-1:0] held_data
);
    typedef struct packed {
        logic              vld;
        logic [DATA_W-1:0] data;
    } hold_t;

    hold_t hold_d, hold_q;

    always_comb begin
        hold_d = hold_q;
        if (slot_en) begin
            hold_d.vld  = in_valid;
            hold_d.data = in_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) hold_q <= '0;
        else        hold_q <= hold_d;
    end

    assign held_vld  = hold_q.vld;
    assign held_data = hold_q.data;

    // R3
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_en |=> $stable({held_vld, held_data}));

    // R3
    hold_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_en |=> (held_vld == $past(in_valid)) && (held_data == $past(in_data)));

endmodule

// File: rtl/hb_rx_capture.sv
module hb_rx_capture #(
    parameter int unsigned DATA_W = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_en,
    input  logic              held_vld,
    input  logic [DATA_W-1:0] held_data,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
    } cap_t;

    cap_t cap_d, cap_q;

    always_comb begin
        cap_d       = cap_q;
        cap_d.valid = slot_en && held_vld;
        if (slot_en && held_vld) cap_d.data = held_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cap_q <= '0;
        else        cap_q <= cap_d;
    end

    assign out_valid = cap_q.valid;
    assign out_data  = cap_q.data;

    // R4
    rx_valid_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(slot_en));

    // R5
    rx_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));

endmodule

// File: rtl/hb_cross_link.sv
module hb_cross_link #(
    parameter int unsigned         DATA_W     = 1,
    parameter int unsigned         TX_LEN     = 8,
    parameter int unsigned         RX_LEN     = 5,
    parameter logic [TX_LEN-1:0]   TX_PATTERN = 8'b0110_1011,
    parameter logic [RX_LEN-1:0]   RX_PATTERN = 5'b11111
) (
    input  logic              clk_s,
    input  logic              rst_s_n,
    input  logic              tx_valid,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_slot,
    input  logic              clk_r,
    input  logic              rst_r_n,
    output logic              rx_valid,
    output logic [DATA_W-1:0] rx_data
);
    logic              s_slot;
    logic              r_slot;
    logic              held_vld;
    logic [DATA_W-1:0] held_data;

    hb_slot_ring #(.LEN(TX_LEN), .PATTERN(TX_PATTERN)) i_tx_ring (
        .clk     (clk_s),
        .rst_n   (rst_s_n),
        .slot_en (s_slot)
    );

    hb_tx_hold #(.DATA_W(DATA_W)) i_tx_hold (
        .clk       (clk_s),
        .rst_n     (rst_s_n),
        .slot_en   (s_slot),
        .in_valid  (tx_valid),
        .in_data   (tx_data),
        .held_vld  (held_vld),
        .held_data (held_data)
    );

    hb_slot_ring #(.LEN(RX_LEN), .PATTERN(RX_PATTERN)) i_rx_ring (
        .clk     (clk_r),
        .rst_n   (rst_r_n),
        .slot_en (r_slot)
    );

    hb_rx_capture #(.DATA_W(DATA_W)) i_rx_cap (
        .clk       (clk_r),
        .rst_n     (rst_r_n),
        .slot_en   (r_slot),
        .held_vld  (held_vld),
        .held_data (held_data),
        .out_valid (rx_valid),
        .out_data  (rx_data)
    );

    assign tx_slot = s_slot;

endmodule

// File: tb/test_hb_cross_link.sv
`timescale 1ns/1ps
module test_hb_cross_link;
    localparam int DW = 8;
    localparam logic [7:0] TXP = 8'b0110_1011;
    localparam int HEARTBEATS = 200;

    logic clk_s, clk_r, rst_s_n, rst_r_n;
    logic tx_valid;
    logic [DW-1:0] tx_data;
    logic tx_slot, tx_slot_sp;
    logic rx_valid, rx_valid_sp;
    logic [DW-1:0] rx_data, rx_data_sp;

    int n_chk = 0, n_err = 0;
    logic [DW-1:0] q_all [0:63];
    logic [DW-1:0] q_one [0:63];
    int wr_all = 0, rd_all = 0, wr_one = 0, rd_one = 0;

    hb_cross_link #(.DATA_W(DW)) i_hb_cross_link (
        .clk_s(clk_s), .rst_s_n(rst_s_n), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_slot(tx_slot), .clk_r(clk_r), .rst_r_n(rst_r_n),
        .rx_valid(rx_valid), .rx_data(rx_data));

    hb_cross_link #(.DATA_W(DW), .RX_PATTERN(5'b00001)) i_hb_cross_link_sparse (
        .clk_s(clk_s), .rst_s_n(rst_s_n), .tx_valid(tx_valid), .tx_data(tx_data),
        .tx_slot(tx_slot_sp), .clk_r(clk_r), .rst_r_n(rst_r_n),
        .rx_valid(rx_valid_sp), .rx_data(rx_data_sp));

    // common base: sender 10 ns (rises 5,15,..), receiver 16 ns (rises 10,26,..); 80 ns heartbeat
    initial begin clk_s = 1'b0; forever #5 clk_s = ~clk_s; end
    initial begin clk_r = 1'b0; #2; forever #8 clk_r = ~clk_r; end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_slot(input int c);
        return TXP[c % 8];
    endfunction

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_err);
        $finish;
    endtask

    initial begin
        #400000;
        check(1'b0, "R6", "watchdog expired", 0, 1);
        finish_run();
    end

    // sender driver
    initial begin
        void'($urandom(32'd20240611));
        rst_s_n = 1'b0; rst_r_n = 1'b0; tx_valid = 1'b0; tx_data = '0;
        #40;
        check(rx_valid == 1'b0, "R1", "rx_valid in reset", int'(rx_valid), 0);
        check(rx_data == '0, "R1", "rx_data in reset", int'(rx_data), 0);
        check(tx_slot == TXP[0], "R1", "tx_slot in reset", int'(tx_slot), int'(TXP[0]));
        #41;
        rst_s_n = 1'b1; rst_r_n = 1'b1;
        for (int c = 0; c < HEARTBEATS * 8 + 24; c++) begin
            int h;
            bit v;
            logic [DW-1:0] d;
            h = c / 8;
            check(tx_slot == exp_slot(c), "R2", "tx_slot phase", int'(tx_slot), int'(exp_slot(c)));
            d = DW'($urandom);
            if (c >= HEARTBEATS * 8)  v = 1'b0;            // drain
            else if (h < 3)           v = 1'b1;            // dense
            else if (h < 5) begin                           // R3/R7: valid only off-slot
                v = !exp_slot(c);
                d = 8'hEE;
            end
            else if (h < 6)           v = 1'b0;
            else                      v = ($urandom % 4) != 0;
            tx_valid = v;
            tx_data  = d;
            if (v && exp_slot(c)) begin
                q_all[wr_all % 64] = d; wr_all++;
                if (c % 8 == 0) begin q_one[wr_one % 64] = d; wr_one++; end
            end
            @(negedge clk_s);
        end
        #200;
        check(rd_all == wr_all, "R6", "words delivered", rd_all, wr_all);
        check(rd_one == wr_one, "R8", "sparse words delivered", rd_one, wr_one);
        check(wr_one < wr_all, "R8", "sparse link drops overwritten words", wr_one, wr_all);
        finish_run();
    end

    // main receiver monitor
    initial begin
        logic [DW-1:0] prev;
        #81;
        @(negedge clk_r);
        prev = rx_data;
        forever begin
            @(negedge clk_r);
            if (rx_valid) begin
                if (rd_all >= wr_all)
                    check(1'b0, "R7", "rx_valid with nothing sent in a slot (R3)", int'(rx_data), -1);
                else begin
                    check(rx_data == q_all[rd_all % 64], "R6", "in-order word",
                          int'(rx_data), int'(q_all[rd_all % 64]));
                    rd_all++;
                end
            end else begin
                check(rx_data == prev, "R5", "rx_data held", int'(rx_data), int'(prev));
            end
            prev = rx_data;
        end
    end

    // sparse receiver monitor
    initial begin
        int rc;
        rc = 0;
        #81;
        @(negedge clk_r);
        forever begin
            @(negedge clk_r);
            if (rx_valid_sp) begin
                check(rc % 5 == 0, "R4", "sparse valid only in receive slot", rc % 5, 0);
                if (rd_one >= wr_one)
                    check(1'b0, "R8", "sparse delivered an overwritten word", int'(rx_data_sp), -1);
                else begin
                    check(rx_data_sp == q_one[rd_one % 64], "R8", "sparse word",
                          int'(rx_data_sp), int'(q_one[rd_one % 64]));
                    rd_one++;
                end
            end
            rc++;
        end
    end

endmodule